// File: doc/BRIEF.md
# Dual-Port Double-Rate Burst-of-Two Static Memory

This block models a static memory with a read port and a write port that work independently and share one address bus. It runs on a single internal clock at twice the interface rate. An internal phase bit divides the edges into two alternating kinds: the rising edge of the primary clock (K phase) and the rising edge of its complement (K# phase). The first clock edge after reset is released is a K phase. Every access moves an uninterruptible burst of two words. The first word uses the even address of a pair and the second word uses the odd address next to it.

A read is requested on a K phase. Its two words come out on the following K# phase and then on the next K phase. While those words are on the bus, a valid flag is high and an echo strobe toggles once per word, so a capturing circuit can align to the data. A write is requested on a K phase. Its first word and byte mask are taken on that phase. Its address, second word and second mask are taken on the next K# phase, and both words are stored at that edge. Because one address is carried on each phase, a read and a write can both be accepted in every cycle.

Top module: `ddr2w_sram`

## Requirements
- R1: After reset, the read data is 0, the valid flag is low and the echo strobe is 0.
- R2: When the read select is low at a K phase edge, the even word of the addressed pair appears on the read data after the next edge (K#), and the odd word appears after the edge after that (K). The valid flag is high for both words. Address bit 0 of the read address is ignored.
- R3: Reads requested on consecutive K phases produce an unbroken stream of words, with the valid flag held high throughout.
- R4: A write selected at a K phase stores the data and mask taken at that edge in the even word of the pair. It stores the data and mask taken at the following K# edge in the odd word. The pair is chosen by the address on the bus at the K# edge, and its bit 0 is ignored.
- R5: Byte-write enables are active low, and byte lane i is data bits [8i+7:8i]. A lane whose enable is high keeps its stored value.
- R6: A low read select that is present only at a K# edge starts no read.
- R7: A low write select that is present only at a K# edge starts no write.
- R8: When a read and a write are accepted in the same cycle on the same pair, the read returns the contents from before that write, and a later read returns the new contents. A read and a write in the same cycle on different pairs both take effect.
- R9: Whenever no read word is being delivered, the valid flag is low and the read data is 0.
- R10: The echo strobe inverts on each edge that delivers a read word and holds its value on every other edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock at twice the interface rate; its edges alternate between K and K# phases |
| rst | input | 1 | Synchronous reset, active high |
| rsel_n | input | 1 | Read select, active low, sampled on K phases |
| wsel_n | input | 1 | Write select, active low, sampled on K phases |
| addr | input | AW | Read address on K phases, write address on K# phases |
| wdata | input | 8*NB | Write data, one word per phase |
| wbyte_n | input | NB | Byte-write enables, active low, one set per phase |
| rdata | output | 8*NB | Read data, 0 when no word is delivered |
| rvalid | output | 1 | High while rdata carries a read word |
| rstrobe | output | 1 | Echo strobe, inverts on each delivered word |

## Verification
The bench counts edges from the release of reset. A read requested at the K edge numbered n is due with its even word after edge n+1 and with its odd word after edge n+2. The driver stores each expected word in a scoreboard under its due edge number. It takes the expected value from a reference array before that cycle's write is applied, which gives the old-data ordering. A monitor samples at every falling edge. It requires the valid flag and a matching word exactly when a scoreboard entry is due, and an idle zero bus at every other sample. It also checks the echo strobe against its value at the previous sample. The effects of writes are observed only through later reads.

// File: rtl/ddr2w_pkg.sv
package ddr2w_pkg;

    localparam int LANE_W = 8;

    typedef enum logic {
        PH_RISE_K  = 1'b0,
        PH_RISE_KB = 1'b1
    } phase_e;

    function automatic phase_e phase_next(input phase_e p);
        return (p == PH_RISE_K) ? PH_RISE_KB : PH_RISE_K;
    endfunction

endpackage

// File: rtl/ddr2w_phase.sv
module ddr2w_phase
    import ddr2w_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    output phase_e ph
);
    always_ff @(posedge clk) begin
        if (rst) ph <= PH_RISE_K;
        else     ph <= phase_next(ph);
    end
endmodule

// File: rtl/ddr2w_wport.sv
module ddr2w_wport
    import ddr2w_pkg::*;
#(
    parameter int AW = 5,
    parameter int NB = 4,
    localparam int DW = NB * LANE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  phase_e        ph,
    input  logic          wsel_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic [NB-1:0] wbyte_n,
    output logic          we,
    output logic [AW-1:0] wbase,
    output logic [DW-1:0] d_even,
    output logic [NB-1:0] m_even,
    output logic [DW-1:0] d_odd,
    output logic [NB-1:0] m_odd
);
    logic pend;

    // first beat is held from the K phase until the K# phase commits the pair
    always_ff @(posedge clk) begin
        if (rst) begin
            pend   <= 1'b0;
            d_even <= '0;
            m_even <= '1;
        end else if (ph == PH_RISE_K) begin
            pend   <= ~wsel_n;
            d_even <= wdata;
            m_even <= wbyte_n;
        end
    end

    assign we    = pend && (ph == PH_RISE_KB);
    assign wbase = {addr[AW-1:1], 1'b0};
    assign d_odd = wdata;
    assign m_odd = wbyte_n;
endmodule

// File: rtl/ddr2w_array.sv
module ddr2w_array
    import ddr2w_pkg::*;
#(
    parameter int AW = 5,
    parameter int NB = 4,
    localparam int DW = NB * LANE_W,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] wbase,
    input  logic [DW-1:0] d_even,
    input  logic [NB-1:0] m_even,
    input  logic [DW-1:0] d_odd,
    input  logic [NB-1:0] m_odd,
    input  logic [AW-1:0] rbase,
    output logic [DW-1:0] q_even,
    output logic [DW-1:0] q_odd
);
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] w_ev, w_od;
    logic [DW-1:0] nxt_even, nxt_odd;

    assign w_ev = wbase;
    assign w_od = wbase | AW'(1);

    // per-lane merge of new and stored bytes
    for (genvar g = 0; g < NB; g++) begin : g_lane
        assign nxt_even[g*LANE_W +: LANE_W] = m_even[g] ? mem[w_ev][g*LANE_W +: LANE_W]
                                                        : d_even[g*LANE_W +: LANE_W];
        assign nxt_odd[g*LANE_W +: LANE_W]  = m_odd[g]  ? mem[w_od][g*LANE_W +: LANE_W]
                                                        : d_odd[g*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk) begin
        if (we) begin
            mem[w_ev] <= nxt_even;
            mem[w_od] <= nxt_odd;
        end
    end

    assign q_even = mem[rbase];
    assign q_odd  = mem[rbase | AW'(1)];
endmodule

// File: rtl/ddr2w_rport.sv
module ddr2w_rport
    import ddr2w_pkg::*;
#(
    parameter int AW = 5,
    parameter int NB = 4,
    localparam int DW = NB * LANE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  phase_e        ph,
    input  logic          rsel_n,
    input  logic [AW-1:0] addr,
    output logic [AW-1:0] rbase,
    input  logic [DW-1:0] q_even,
    input  logic [DW-1:0] q_odd,
    output logic [DW-1:0] rdata,
    output logic          rvalid,
    output logic          rstrobe
);
    logic          pend;
    logic          hold_v;
    logic [DW-1:0] hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend    <= 1'b0;
            rbase   <= '0;
            hold    <= '0;
            hold_v  <= 1'b0;
            rdata   <= '0;
            rvalid  <= 1'b0;
            rstrobe <= 1'b0;
        end else if (ph == PH_RISE_K) begin
            pend   <= ~rsel_n;
            rbase  <= {addr[AW-1:1], 1'b0};
            hold_v <= 1'b0;
            if (hold_v) begin
                rdata   <= hold;
                rvalid  <= 1'b1;
                rstrobe <= ~rstrobe;
            end else begin
                rdata  <= '0;
                rvalid <= 1'b0;
            end
        end else begin
            // both words sampled here, before a same-edge write lands
            if (pend) begin
                rdata   <= q_even;
                hold    <= q_odd;
                hold_v  <= 1'b1;
                rvalid  <= 1'b1;
                rstrobe <= ~rstrobe;
            end else begin
                rdata  <= '0;
                rvalid <= 1'b0;
                hold_v <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/ddr2w_sram.sv
module ddr2w_sram
    import ddr2w_pkg::*;
#(
    parameter int AW = 5,
    parameter int NB = 4,
    localparam int DW = NB * LANE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rsel_n,
    input  logic          wsel_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic [NB-1:0] wbyte_n,
    output logic [DW-1:0] rdata,
    output logic          rvalid,
    output logic          rstrobe
);
    phase_e        ph;
    logic          at_k;
    logic          we;
    logic [AW-1:0] wbase, rbase;
    logic [DW-1:0] d_even, d_odd, q_even, q_odd;
    logic [NB-1:0] m_even, m_odd;

    assign at_k = (ph == PH_RISE_K);

    ddr2w_phase u_phase (.clk(clk), .rst(rst), .ph(ph));

    ddr2w_wport #(.AW(AW), .NB(NB)) u_wport (
        .clk(clk), .rst(rst), .ph(ph), .wsel_n(wsel_n), .addr(addr),
        .wdata(wdata), .wbyte_n(wbyte_n), .we(we), .wbase(wbase),
        .d_even(d_even), .m_even(m_even), .d_odd(d_odd), .m_odd(m_odd)
    );

    ddr2w_array #(.AW(AW), .NB(NB)) u_array (
        .clk(clk), .we(we), .wbase(wbase), .d_even(d_even), .m_even(m_even),
        .d_odd(d_odd), .m_odd(m_odd), .rbase(rbase), .q_even(q_even), .q_odd(q_odd)
    );

    ddr2w_rport #(.AW(AW), .NB(NB)) u_rport (
        .clk(clk), .rst(rst), .ph(ph), .rsel_n(rsel_n), .addr(addr),
        .rbase(rbase), .q_even(q_even), .q_odd(q_odd),
        .rdata(rdata), .rvalid(rvalid), .rstrobe(rstrobe)
    );
endmodule

// File: rtl/ddr2w_sram_chk.sv
module ddr2w_sram_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          rd_n,
    input logic          at_k,
    input logic          valid,
    input logic          echo,
    input logic [DW-1:0] q
);
    AST_RD_FIRST_WORD: assert property (@(posedge clk) disable iff (rst)
        (at_k && !rd_n) |-> ##2 valid); // R2
    AST_RD_SECOND_WORD: assert property (@(posedge clk) disable iff (rst)
        (at_k && !rd_n) |-> ##3 valid); // R2
    AST_BURST_OF_TWO: assert property (@(posedge clk) disable iff (rst)
        $rose(valid) |=> valid); // R3
    AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (rst)
        !valid |-> (q == '0)); // R9
    AST_ECHO_TOGGLE: assert property (@(posedge clk) disable iff (rst)
        valid |-> (echo != $past(echo))); // R10
    AST_ECHO_HOLD: assert property (@(posedge clk) disable iff (rst)
        !valid |-> $stable(echo)); // R10
endmodule

bind ddr2w_sram ddr2w_sram_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst(rst), .rd_n(rsel_n), .at_k(at_k),
    .valid(rvalid), .echo(rstrobe), .q(rdata)
);

// File: tb/tb_ddr2w_sram.sv
`timescale 1ns/1ps
module tb_ddr2w_sram;
    localparam int AW = 5;
    localparam int NB = 4;
    localparam int DW = NB * 8;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          rsel_n = 1'b1, wsel_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [NB-1:0] wbyte_n = '1;
    logic [DW-1:0] rdata;
    logic          rvalid, rstrobe;

    ddr2w_sram #(.AW(AW), .NB(NB)) dut (
        .clk(clk), .rst(rst), .rsel_n(rsel_n), .wsel_n(wsel_n), .addr(addr),
        .wdata(wdata), .wbyte_n(wbyte_n), .rdata(rdata), .rvalid(rvalid), .rstrobe(rstrobe)
    );

    always #4 clk = ~clk;

    int unsigned cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    logic [DW-1:0] model [DEPTH];
    int unsigned   due_q[$];
    logic [DW-1:0] val_q[$];
    string         tag_q[$];
    logic          prev_echo = 1'b0;

    task automatic check(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at edge %0d", tag, act, exp, cyc);
        end
    endtask

    // monitor: pops scoreboard entries when due
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (due_q.size() > 0 && due_q[0] == cyc) begin
                check(rvalid === 1'b1 && rdata === val_q[0], tag_q[0], {rvalid, rdata[DW-2:0]} , val_q[0]);
                void'(due_q.pop_front());
                void'(val_q.pop_front());
                void'(tag_q.pop_front());
            end else begin
                check(rvalid === 1'b0 && rdata === '0, "R9 idle bus", rdata, '0);
            end
            if (rvalid) check(rstrobe !== prev_echo, "R10 echo toggle", DW'(rstrobe), DW'(!prev_echo));
            else        check(rstrobe === prev_echo, "R10 echo hold", DW'(rstrobe), DW'(prev_echo));
            prev_echo = rstrobe;
        end
    end

    // driver: one full cycle, entered at the falling edge before a K edge
    task automatic cyc2(input bit rd, input int ra, input bit wr, input int wa,
                        input logic [DW-1:0] d0, input logic [NB-1:0] m0,
                        input logic [DW-1:0] d1, input logic [NB-1:0] m1,
                        input bit rd_kb, input bit wr_kb, input string tag);
        int eb;
        rsel_n = !rd; wsel_n = !wr; addr = AW'(ra); wdata = d0; wbyte_n = m0;
        if (rd) begin
            eb = ra & ~1;
            due_q.push_back(cyc + 2); val_q.push_back(model[eb]);     tag_q.push_back(tag);
            due_q.push_back(cyc + 3); val_q.push_back(model[eb + 1]); tag_q.push_back(tag);
        end
        @(posedge clk); @(negedge clk);
        rsel_n = !rd_kb; wsel_n = !wr_kb; addr = AW'(wa); wdata = d1; wbyte_n = m1;
        @(posedge clk);
        if (wr) begin
            eb = wa & ~1;
            for (int b = 0; b < NB; b++) begin
                if (!m0[b]) model[eb][b*8 +: 8] = d0[b*8 +: 8];
                if (!m1[b]) model[eb + 1][b*8 +: 8] = d1[b*8 +: 8];
            end
        end
        @(negedge clk);
        rsel_n = 1'b1; wsel_n = 1'b1; wbyte_n = '1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc2(0, 0, 0, 0, '0, '1, '0, '1, 0, 0, "idle");
    endtask

    task automatic wr_pair(input int wa, input logic [DW-1:0] d0, input logic [DW-1:0] d1);
        cyc2(0, 0, 1, wa, d0, '0, d1, '0, 0, 0, "R4");
    endtask

    task automatic rd_pair(input int ra, input string tag);
        cyc2(1, ra, 0, 0, '0, '1, '0, '1, 0, 0, tag);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #1600000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) model[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check(rdata === '0 && rvalid === 1'b0 && rstrobe === 1'b0, "R1 reset state",
              {rdata[DW-1:2], rvalid, rstrobe}, '0);
        rst = 1'b0;
        // clear the array through the write port
        for (int a = 0; a < DEPTH; a += 2) wr_pair(a, '0, '0);
        // R4: full-word pair write, read with address bit 0 set (R2)
        wr_pair(5, 32'h1122_3344, 32'h5566_7788);
        idle(1);
        rd_pair(5, "R2 R4 read pair");
        // R5: masked lanes keep old bytes
        cyc2(0, 0, 1, 4, 32'hAAAA_AAAA, 4'b1010, 32'hBBBB_BBBB, 4'b0101, 0, 0, "R5");
        rd_pair(4, "R5 byte mask");
        // R3: back-to-back reads
        wr_pair(8,  32'h0808_0808, 32'h0909_0909);
        wr_pair(10, 32'h1010_1010, 32'h1111_1111);
        wr_pair(12, 32'h1212_1212, 32'h1313_1313);
        rd_pair(8,  "R3 stream");
        rd_pair(10, "R3 stream");
        rd_pair(12, "R3 stream");
        idle(1);
        // R8: same pair read and write in one cycle -> old data first
        cyc2(1, 12, 1, 13, 32'hC0C0_C0C0, '0, 32'hC1C1_C1C1, '0, 0, 0, "R8 old data");
        rd_pair(12, "R8 new data");
        // R8: different pairs in one cycle
        cyc2(1, 4, 1, 20, 32'h2020_2020, '0, 32'h2121_2121, '0, 0, 0, "R8 split pairs");
        rd_pair(20, "R8 split pairs");
        idle(1);
        // R6: read select only at K# is ignored
        cyc2(0, 0, 0, 8, '0, '1, '0, '1, 1, 0, "R6");
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(rvalid === 1'b0, "R6 no read from K# select", DW'(rvalid), '0);
        end
        // R7: write select only at K# is ignored
        cyc2(0, 0, 0, 8, 32'hDEAD_BEEF, '0, 32'hFEED_F00D, '0, 0, 1, "R7");
        rd_pair(8, "R7 pair unchanged");
        // mixed traffic
        for (int i = 0; i < 60; i++) begin
            cyc2(bit'($urandom % 2), int'($urandom % DEPTH), bit'($urandom % 2), int'($urandom % DEPTH),
                 $urandom, NB'($urandom), $urandom, NB'($urandom), 0, 0, "R2 mixed");
        end
        idle(3);
        check(due_q.size() == 0, "R2 all reads delivered", DW'(due_q.size()), '0);
        finish_run();
    end
endmodule